// File: doc/BRIEF.md
# Serial Frame Controller for a Sampling Converter

This block is the digital side of a small successive-approximation converter. A host drives an active-low select and a serial clock. Both are sampled on the system clock `clk_i`. Lowering the select samples the input and starts a conversion. The block then moves a parallel result from a converter stub onto a tri-stateable serial output as a 16-clock frame. The frame ends on the serial clock's falling edges, or early when the select is released.

The block tracks when conversion ends and acquisition begins. It decides from where the select is released whether a frame finished, was aborted, or sent the block into powerdown. It also counts the dummy frames still needed after a wake-up. Analog sampling and power gating are not modelled; status outputs stand in for them. The high-impedance state of the data pin is shown by an enable output that is low.

Top module: `sadc_serial_frame`

## Requirements
- R1: After reset the data output enable is 0, powered_down_o, warming_o, converting_o and data_valid_o are 0, and acquiring_o is 1.
- R2: A falling edge on the select sets the data enable to 1 and drives a 0 on the data line. It also sets converting_o to 1, clears acquiring_o, and pulses sample_o for one clock.
- R3: Frame bit k is the value on the data line after falling edge k of the serial clock; bit 0 is the value right after the select falls. Bits 0 and 1 are 0. Bits 2 to RES_W+1 carry the result, most significant bit first. The remaining bits up to bit 15 are 0.
- R4: The data enable is 0 whenever the select is high, and from the 16th serial-clock falling edge until the next select fall.
- R5: The conversion ends on the first serial-clock rising edge after falling edge RES_W+1. At that edge converting_o falls and acquiring_o rises together.
- R6: data_valid_o pulses for one clock at the end of conversion, and only if three things held when the frame started: the block was not powered down, no wake-up frames were pending, and acquiring_o was 1.
- R7: Releasing the select before the conversion ends aborts it. converting_o drops, acquiring_o stays 0, and the next frame gives no data_valid_o. The frame after that is valid again.
- R8: Releasing the select when the falling-edge count is from 2 to 9 sets powered_down_o. Counts of 0, 1 or 10 and above do not.
- R9: While powered down, a frame released after 11 or more falling edges clears powered_down_o and sets warming_o. A frame released at 10 or fewer leaves the block powered down. The wake-up frame gives no data_valid_o.
- R10: After a wake-up, the next WAKE_FRAMES-1 frames whose conversion completes give no data_valid_o. warming_o clears at the end of conversion of the last of them.
- R11: If the select rises in the same clock as the serial-clock rising edge that would end conversion, the abort wins. No data_valid_o is produced, and acquiring_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select |
| sclk_i | input | 1 | Serial clock |
| result_i | input | RES_W | Conversion result from the converter stub |
| sample_o | output | 1 | One-clock pulse when the input is sampled |
| sdo_o | output | 1 | Serial data |
| sdo_en_o | output | 1 | Data output enable; 0 means high impedance |
| converting_o | output | 1 | Conversion in progress |
| acquiring_o | output | 1 | Acquisition phase reached |
| powered_down_o | output | 1 | Block is in powerdown |
| warming_o | output | 1 | Wake-up dummy frames still pending |
| data_valid_o | output | 1 | One-clock pulse marking a valid result |

## Verification
The end of conversion and an abort can land in the same clock. This happens when the select rises together with the serial-clock rising edge that follows falling edge RES_W+1. The bench provokes it by lifting both pins in a single drive step right after that falling edge. It judges the result by three things: no data_valid_o pulse, acquiring_o left at 0, and no data_valid_o in the following frame. A recovery frame after that is expected to be valid.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int FRAME_LEN  = 16;
  localparam int LEAD_ZEROS = 2;
  localparam int CNT_W      = $clog2(FRAME_LEN + 1);
  // release window (falling-edge count) that forces powerdown
  localparam int PD_LO      = 2;
  localparam int PD_HI      = 9;
  // minimum falling edges in a frame that wakes the block
  localparam int WAKE_MIN   = 11;
endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_fall_o,
  output logic sclk_rise_o
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_ni;
      sclk_q <= sclk_i;
    end
  end

  assign cs_fall_o   = cs_q & ~cs_ni;
  assign cs_rise_o   = ~cs_q & cs_ni;
  // serial clock edges only count while selected
  assign sclk_fall_o = sclk_q & ~sclk_i & ~cs_ni;
  assign sclk_rise_o = ~sclk_q & sclk_i & ~cs_ni;
endmodule

// File: rtl/sadc_frame_shifter.sv
module sadc_frame_shifter
  import sadc_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             sclk_rise_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_en_o,
  output logic             converting_o,
  output logic             conv_end_o,
  output logic [CNT_W-1:0] fall_cnt_o
);
  localparam int PAD_W    = FRAME_LEN - LEAD_ZEROS - RES_W;
  localparam int END_FALL = LEAD_ZEROS + RES_W - 1;

  logic [FRAME_LEN-1:0] shreg_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 en_q, conv_q;

  assign conv_end_o = sclk_rise_i & conv_q & (cnt_q >= CNT_W'(END_FALL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      conv_q  <= 1'b0;
    end else if (cs_fall_i) begin
      shreg_q <= {{LEAD_ZEROS{1'b0}}, result_i, {PAD_W{1'b0}}};
      cnt_q   <= '0;
      en_q    <= 1'b1;
      conv_q  <= 1'b1;
    end else if (cs_rise_i) begin
      en_q   <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      if (sclk_fall_i && cnt_q < CNT_W'(FRAME_LEN)) begin
        shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b0};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FRAME_LEN - 1)) en_q <= 1'b0;
      end
      if (conv_end_o) conv_q <= 1'b0;
    end
  end

  assign sdo_o        = en_q & shreg_q[FRAME_LEN-1];
  assign sdo_en_o     = en_q;
  assign converting_o = conv_q;
  assign fall_cnt_o   = cnt_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_LEN));
  p_lead_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> !sdo_o);
  p_conv_end_late_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_q) |-> ($past(cs_rise_i) || $past(cnt_q) >= CNT_W'(END_FALL)));
endmodule

// File: rtl/sadc_power_ctl.sv
module sadc_power_ctl
  import sadc_pkg::*;
#(
  parameter int WAKE_FRAMES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             conv_end_i,
  input  logic [CNT_W-1:0] fall_cnt_i,
  output logic             sample_o,
  output logic             acquiring_o,
  output logic             powered_down_o,
  output logic             warming_o,
  output logic             data_valid_o
);
  localparam int WK_W = $clog2(WAKE_FRAMES + 1);

  logic            pd_q, acq_q, ok_q, valid_q, sample_q;
  logic [WK_W-1:0] wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q     <= 1'b0;
      acq_q    <= 1'b1;
      ok_q     <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= 1'b0;
      wake_q   <= '0;
    end else begin
      valid_q  <= 1'b0;
      sample_q <= cs_fall_i;
      if (cs_fall_i) begin
        acq_q <= 1'b0;
        ok_q  <= acq_q & ~pd_q & (wake_q == '0);
      end
      if (conv_end_i) begin
        acq_q   <= 1'b1;
        valid_q <= ok_q;
        if (!pd_q && wake_q != '0) wake_q <= wake_q - 1'b1;
      end
      if (cs_rise_i) begin
        if (fall_cnt_i >= CNT_W'(PD_LO) && fall_cnt_i <= CNT_W'(PD_HI)) begin
          pd_q   <= 1'b1;
          wake_q <= '0;
        end else if (pd_q && fall_cnt_i >= CNT_W'(WAKE_MIN)) begin
          pd_q   <= 1'b0;
          wake_q <= WK_W'(WAKE_FRAMES - 1);
        end
      end
    end
  end

  assign sample_o       = sample_q;
  assign acquiring_o    = acq_q;
  assign powered_down_o = pd_q;
  assign warming_o      = wake_q != '0;
  assign data_valid_o   = valid_q;

  p_no_valid_in_pd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> !valid_q);
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_pd_on_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> $past(cs_rise_i));
  p_wake_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q <= WK_W'(WAKE_FRAMES - 1));
endmodule

// File: rtl/sadc_serial_frame.sv
module sadc_serial_frame
  import sadc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int WAKE_FRAMES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sample_o,
  output logic             sdo_o,
  output logic             sdo_en_o,
  output logic             converting_o,
  output logic             acquiring_o,
  output logic             powered_down_o,
  output logic             warming_o,
  output logic             data_valid_o
);
  logic             cs_fall, cs_rise, sclk_fall, sclk_rise, conv_end;
  logic [CNT_W-1:0] fall_cnt;

  sadc_edge_det u_edge (
    .clk_i, .rst_ni, .cs_ni, .sclk_i,
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sclk_fall_o(sclk_fall), .sclk_rise_o(sclk_rise)
  );

  sadc_frame_shifter #(.RES_W(RES_W)) u_shift (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .result_i, .sdo_o, .sdo_en_o, .converting_o,
    .conv_end_o(conv_end), .fall_cnt_o(fall_cnt)
  );

  sadc_power_ctl #(.WAKE_FRAMES(WAKE_FRAMES)) u_pwr (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .conv_end_i(conv_end), .fall_cnt_i(fall_cnt),
    .sample_o, .acquiring_o, .powered_down_o, .warming_o, .data_valid_o
  );

  p_hiz_cs_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !sdo_en_o);
  p_valid_at_conv_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (!converting_o && $past(converting_o) && acquiring_o));
  p_abort_no_acq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && converting_o) |=> !acquiring_o);
endmodule

// File: tb/tb_sadc_serial_frame.sv
module tb_sadc_serial_frame;
  localparam int RES_W    = 10;
  localparam int WAKE     = 3;
  localparam int END_FALL = RES_W + 1;
  localparam int NVEC     = 6;
  localparam logic [RES_W-1:0] VEC [NVEC] =
    '{10'h2A5, 10'h000, 10'h3FF, 10'h155, 10'h001, 10'h200};

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sclk_i = 1'b1;
  logic [RES_W-1:0] result_i = '0;
  logic sample_o, sdo_o, sdo_en_o, converting_o, acquiring_o;
  logic powered_down_o, warming_o, data_valid_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  sadc_serial_frame #(.RES_W(RES_W), .WAKE_FRAMES(WAKE)) dut (
    .clk_i(clk), .rst_ni, .cs_ni, .sclk_i, .result_i, .sample_o, .sdo_o,
    .sdo_en_o, .converting_o, .acquiring_o, .powered_down_o, .warming_o,
    .data_valid_o
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog R1: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s);
    cs_ni = c; sclk_i = s;
    @(posedge clk); #2;
  endtask

  function automatic int exp_bit(input logic [RES_W-1:0] r, input int k);
    if (k >= 2 && k <= RES_W + 1) return int'(r[RES_W + 1 - k]);
    return 0;
  endfunction

  // mode 0: last rise then release; 1: release with sclk rise; 2: release with sclk low
  task automatic frame(input logic [RES_W-1:0] res, input int nf, input int mode,
                       input bit cb, output int va, output int ea);
    va = -1; ea = -1; result_i = res;
    drive(1'b0, 1'b1);
    if (cb) begin
      chk("R2 en", sdo_en_o, 1); chk("R2 sdo", sdo_o, 0);
      chk("R2 conv", converting_o, 1); chk("R2 sample", sample_o, 1);
      chk("R2 acq", acquiring_o, 0);
    end
    for (int k = 1; k <= nf; k++) begin
      drive(1'b0, 1'b0);
      if (cb) begin
        if (k < 16) begin
          chk("R3 en", sdo_en_o, 1); chk("R3 bit", sdo_o, exp_bit(res, k));
        end else chk("R4 hiz16", sdo_en_o, 0);
      end
      if (k < nf || mode == 0) begin
        drive(1'b0, 1'b1);
        if (data_valid_o) va = k;
        if (ea < 0 && !converting_o) ea = k;
      end
    end
    if (mode == 2) drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    if (data_valid_o) va = 99;
    if (cb) chk("R4 hiz cs", sdo_en_o, 0);
    drive(1'b1, 1'b1);
    if (data_valid_o) va = 99;
    drive(1'b1, 1'b1);
  endtask

  initial begin
    int va, ea;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    // R1 reset state
    chk("R1 en", sdo_en_o, 0); chk("R1 pd", powered_down_o, 0);
    chk("R1 warm", warming_o, 0); chk("R1 conv", converting_o, 0);
    chk("R1 valid", data_valid_o, 0); chk("R1 acq", acquiring_o, 1);
    drive(1'b1, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      frame(VEC[i], 16, 0, 1'b1, va, ea);
      chk("R5 end", ea, END_FALL);
      chk("R5 acq", acquiring_o, 1);
      chk("R6 valid", va, END_FALL);
    end

    // R7 release before the ending rise
    frame(10'h0F0, END_FALL, 2, 1'b0, va, ea);
    chk("R7 valid", va, -1); chk("R7 conv", converting_o, 0);
    chk("R7 acq", acquiring_o, 0); chk("R7 pd", powered_down_o, 0);
    frame(10'h123, 16, 0, 1'b1, va, ea);
    chk("R7 next invalid", va, -1);
    frame(10'h321, 16, 0, 1'b1, va, ea);
    chk("R7 recovered", va, END_FALL);

    // R11 release together with the ending rise
    frame(10'h0AA, END_FALL, 1, 1'b0, va, ea);
    chk("R11 valid", va, -1); chk("R11 acq", acquiring_o, 0);
    chk("R11 conv", converting_o, 0);
    frame(10'h1AA, 16, 0, 1'b0, va, ea);
    chk("R11 next invalid", va, -1);
    frame(10'h2AA, 16, 0, 1'b0, va, ea);
    chk("R11 recovered", va, END_FALL);

    // R8 window boundaries
    frame(10'h011, 1, 2, 1'b0, va, ea);
    chk("R8 cnt1", powered_down_o, 0);
    frame(10'h011, 16, 0, 1'b0, va, ea);
    frame(10'h012, 10, 2, 1'b0, va, ea);
    chk("R8 cnt10", powered_down_o, 0);
    frame(10'h013, 16, 0, 1'b0, va, ea);
    frame(10'h014, 9, 2, 1'b0, va, ea);
    chk("R8 cnt9", powered_down_o, 1); chk("R8 hiz", sdo_en_o, 0);

    // R9 / R10 wake-up
    frame(10'h015, 10, 0, 1'b0, va, ea);
    chk("R9 stay pd", powered_down_o, 1); chk("R9 valid", va, -1);
    frame(10'h016, 16, 0, 1'b0, va, ea);
    chk("R9 woke", powered_down_o, 0); chk("R9 warm", warming_o, 1);
    chk("R9 valid", va, -1);
    frame(10'h017, 16, 0, 1'b0, va, ea);
    chk("R10 dummy1", va, -1); chk("R10 warm1", warming_o, 1);
    frame(10'h018, 16, 0, 1'b0, va, ea);
    chk("R10 dummy2", va, -1); chk("R10 warm2", warming_o, 0);
    frame(10'h2C3, 16, 0, 1'b1, va, ea);
    chk("R10 valid", va, END_FALL);

    // R8 lower edge, then R9 wake at exactly 11 falls
    frame(10'h019, 2, 2, 1'b0, va, ea);
    chk("R8 cnt2", powered_down_o, 1);
    frame(10'h01A, 11, 0, 1'b0, va, ea);
    chk("R9 wake11", powered_down_o, 0); chk("R9 warm11", warming_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule